// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit timer whose counter runs downward. Each step is taken on a prescaled tick drawn from one of several tick-enable inputs. When the counter holds the compare value on a step, the block sets a sticky compare flag. It can then raise a level interrupt and act on an output pin. Software controls the block through a small register bus with these five registers:

- control
- status
- load
- compare
- a read-only counter view

After each reload the counter restarts from the load value. Without reload it wraps through the full 32-bit range. The counter can be written directly through the load register. An enable edge can restart it from the load value, and a self-clearing software reset returns every register to its reset state. Three hold inputs freeze counting in debug, wait and stop conditions. A matching run bit in the control register overrides each of them.

Top module: `dncnt_timer`

Register offsets (byte addresses):

| Offset | Register |
|--------|----------|
| 0x00 | control |
| 0x04 | status |
| 0x08 | load |
| 0x0C | compare |
| 0x10 | counter (read-only) |

Control bits:

| Bit(s) | Function |
|--------|----------|
| 0 | enable |
| 1 | restart-on-enable |
| 2 | interrupt enable |
| 3 | reload |
| 15:4 | prescale |
| 16 | software reset |
| 17 | load overwrite |
| 18 | debug run |
| 19 | wait run |
| 21 | stop run |
| 23:22 | output action |
| 25:24 | tick source |

## Requirements
- R1: After reset the register values are: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF, with `irq` and `cmp_out` low. Read data appears on `bus_rdata` one clock after the address is presented. Control bits 16 and 20 always read as 0.
- R2: A prescale value P divides the selected tick by P+1. A value of 0 passes every tick through. The prescaler count clears on a load overwrite, a restart and a software reset.
- R3: Tick source 00 selects no clock, so the counter holds. Codes 01, 10 and 11 select `tick_src[0]`, `tick_src[1]` and `tick_src[2]`.
- R4: While enabled, the counter decrements by one on each prescaled tick. With reload clear it steps from 0 to 0xFFFFFFFF.
- R5: With reload (control bit 3) set, a step taken at 0 loads the counter from the load register.
- R6: A compare event occurs on a prescaled step where the counter value before the step equals the compare register. The event sets status bit 0.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. A coincident compare event wins.
- R8: `irq` follows (flag AND interrupt enable) one clock later. Clearing the enable drops `irq` without clearing the flag.
- R9: The output action field sets what a compare event does to `cmp_out`:
  - 00 leaves it unchanged.
  - 01 toggles it.
  - 10 drives it low.
  - 11 drives it high.
- R10: A control write that sets enable (bit 0) while enable is 0 restarts the counter from the load value, if restart-on-enable (bit 1) is 1 in the same write. With bit 1 at 0, counting resumes from the held value.
- R11: While load overwrite (bit 17) is 1, a load-register write also writes the counter in the same clock. While bit 17 is 0, the counter is untouched.
- R12: A control write with bit 16 set returns all registers, the counter and `cmp_out` to their reset values in one clock. Bit 16 is never stored.
- R13: Counting freezes while `hold_dbg`, `hold_wait` or `hold_stop` is high, unless the matching run bit (18, 19 or 21) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (5) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | DW (32) | Registered read data |
| tick_src | input | NSRC (3) | Count tick enables, one per source |
| hold_dbg | input | 1 | Debug-mode count hold |
| hold_wait | input | 1 | Wait-mode count hold |
| hold_stop | input | 1 | Stop-mode count hold |
| irq | output | 1 | Registered level interrupt |
| cmp_out | output | 1 | Compare-driven output pin |

## Verification
A write is applied on the edge after it is driven, and a read returns data one edge after the address. The counter therefore steps on each edge that follows the enabling write, up to and including the edge of the disabling write, so a run left open for k idle clocks yields k+1 ticks. The compare flag and `cmp_out` change on the same edge as the matching step. `irq` follows the flag one edge later. Every check samples on the falling edge after the clock edge counted for that result, so that edge alone decides the expected value.

// File: rtl/dncnt_timer_pkg.sv
package dncnt_timer_pkg;

  localparam int PRESC_W = 12;
  localparam int CSRC_W  = 2;
  localparam int CTRL_W  = 32;

  // byte offsets of the register map
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_LOAD = 'h08;
  localparam int OFS_CMP  = 'h0C;
  localparam int OFS_CNT  = 'h10;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_IEN   = 2;
  localparam int B_RLD   = 3;
  localparam int B_PRE   = 4;
  localparam int B_SWR   = 16;
  localparam int B_OVW   = 17;
  localparam int B_DBG   = 18;
  localparam int B_WAIT  = 19;
  localparam int B_STOP  = 21;
  localparam int B_OM    = 22;
  localparam int B_CS    = 24;

  typedef enum logic [1:0] {
    OM_NONE   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_LOW    = 2'b10,
    OM_HIGH   = 2'b11
  } outmode_e;

  typedef struct packed {
    logic [CSRC_W-1:0]  csel;
    logic [1:0]         omode;
    logic               stop_run;
    logic               wait_run;
    logic               dbg_run;
    logic               ovw;
    logic [PRESC_W-1:0] presc;
    logic               rld;
    logic               ien;
    logic               enmod;
    logic               en;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.csel     = w[B_CS +: CSRC_W];
    c.omode    = w[B_OM +: 2];
    c.stop_run = w[B_STOP];
    c.wait_run = w[B_WAIT];
    c.dbg_run  = w[B_DBG];
    c.ovw      = w[B_OVW];
    c.presc    = w[B_PRE +: PRESC_W];
    c.rld      = w[B_RLD];
    c.ien      = w[B_IEN];
    c.enmod    = w[B_ENMOD];
    c.en       = w[B_EN];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[B_CS +: CSRC_W]   = c.csel;
    w[B_OM +: 2]        = c.omode;
    w[B_STOP]           = c.stop_run;
    w[B_WAIT]           = c.wait_run;
    w[B_DBG]            = c.dbg_run;
    w[B_OVW]            = c.ovw;
    w[B_PRE +: PRESC_W] = c.presc;
    w[B_RLD]            = c.rld;
    w[B_IEN]            = c.ien;
    w[B_ENMOD]          = c.enmod;
    w[B_EN]             = c.en;
    return w;
  endfunction

endpackage

// File: rtl/dncnt_regs.sv
module dncnt_regs
  import dncnt_timer_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_we,
  input  logic [DW-1:0]      cnt_val,
  input  logic               cmp_evt,
  input  logic               hold_dbg,
  input  logic               hold_wait,
  input  logic               hold_stop,
  output logic               run,
  output logic [CSRC_W-1:0]  csel,
  output logic [PRESC_W-1:0] presc,
  output logic               rld,
  output logic [1:0]         omode,
  output logic [DW-1:0]      load_val,
  output logic [DW-1:0]      cmp_val,
  output logic               flag,
  output logic               restart,
  output logic               ovw_wr,
  output logic               swr,
  output logic               irq,
  output logic [DW-1:0]      bus_rdata
);

  ctrl_t ctrl_q;
  logic  wr_ctrl, wr_stat, wr_load, wr_cmp;

  assign wr_ctrl = bus_we && (bus_addr == AW'(OFS_CTRL));
  assign wr_stat = bus_we && (bus_addr == AW'(OFS_STAT));
  assign wr_load = bus_we && (bus_addr == AW'(OFS_LOAD));
  assign wr_cmp  = bus_we && (bus_addr == AW'(OFS_CMP));

  assign swr     = wr_ctrl && bus_wdata[B_SWR];
  assign restart = wr_ctrl && !bus_wdata[B_SWR] && bus_wdata[B_EN]
                   && bus_wdata[B_ENMOD] && !ctrl_q.en;
  assign ovw_wr  = wr_load && ctrl_q.ovw;

  // count permission: enable, minus any hold whose run bit is clear
  assign run = ctrl_q.en
             && !(hold_dbg  && !ctrl_q.dbg_run)
             && !(hold_wait && !ctrl_q.wait_run)
             && !(hold_stop && !ctrl_q.stop_run);

  assign csel  = ctrl_q.csel;
  assign presc = ctrl_q.presc;
  assign rld   = ctrl_q.rld;
  assign omode = ctrl_q.omode;

  always_ff @(posedge clk) begin
    if (rst || swr) begin
      ctrl_q   <= '0;
      load_val <= '1;
      cmp_val  <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_unpack(bus_wdata[CTRL_W-1:0]);
      if (wr_load) load_val <= bus_wdata;
      if (wr_cmp)  cmp_val  <= bus_wdata;
      if (cmp_evt)
        flag <= 1'b1;
      else if (wr_stat && bus_wdata[0])
        flag <= 1'b0;
      irq <= flag && ctrl_q.ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        AW'(OFS_CTRL): bus_rdata <= DW'(ctrl_pack(ctrl_q));
        AW'(OFS_STAT): bus_rdata <= DW'(flag);
        AW'(OFS_LOAD): bus_rdata <= load_val;
        AW'(OFS_CMP):  bus_rdata <= cmp_val;
        AW'(OFS_CNT):  bus_rdata <= cnt_val;
        default:       bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dncnt_prescale.sv
module dncnt_prescale
  import dncnt_timer_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               run,
  input  logic [CSRC_W-1:0]  csel,
  input  logic [PRESC_W-1:0] presc,
  input  logic [NSRC-1:0]    tick_src,
  output logic               fire
);

  localparam int NSEL = 2 ** CSRC_W;

  logic [NSEL-1:0]    src_vec;
  logic [PRESC_W-1:0] pcnt;
  logic               step;

  assign src_vec[0] = 1'b0;  // code 0: no count clock

  for (genvar g = 1; g < NSEL; g++) begin : g_src
    if (g <= NSRC) begin : g_on
      assign src_vec[g] = tick_src[g-1];
    end else begin : g_off
      assign src_vec[g] = 1'b0;
    end
  end

  assign step = run && src_vec[csel] && !clr;
  assign fire = step && (pcnt == presc);

  always_ff @(posedge clk) begin
    if (rst || clr)
      pcnt <= '0;
    else if (step)
      pcnt <= fire ? '0 : pcnt + 1'b1;
  end

endmodule

// File: rtl/dncnt_core.sv
module dncnt_core
  import dncnt_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swr,
  input  logic          restart,
  input  logic          ovw_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] cmp_val,
  input  logic          rld,
  input  logic [1:0]    omode,
  input  logic          fire,
  output logic [DW-1:0] cnt,
  output logic          cmp_evt,
  output logic          cmp_out
);

  outmode_e om;
  assign om = outmode_e'(omode);

  assign cmp_evt = fire && !swr && !restart && !ovw_wr && (cnt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst || swr) begin
      cnt <= '1;
    end else if (restart) begin
      cnt <= load_val;
    end else if (ovw_wr) begin
      cnt <= wdata;
    end else if (fire) begin
      if (cnt == '0)
        cnt <= rld ? load_val : '1;
      else
        cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || swr) begin
      cmp_out <= 1'b0;
    end else if (cmp_evt) begin
      case (om)
        OM_TOGGLE: cmp_out <= !cmp_out;
        OM_LOW:    cmp_out <= 1'b0;
        OM_HIGH:   cmp_out <= 1'b1;
        default:   cmp_out <= cmp_out;
      endcase
    end
  end

endmodule

// File: rtl/dncnt_timer.sv
module dncnt_timer
  import dncnt_timer_pkg::*;
#(
  parameter int AW   = 5,
  parameter int DW   = 32,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_we,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] tick_src,
  input  logic            hold_dbg,
  input  logic            hold_wait,
  input  logic            hold_stop,
  output logic            irq,
  output logic            cmp_out
);

  logic               run, rld, flag_q, restart, ovw_wr, swr, fire, cmp_evt;
  logic [CSRC_W-1:0]  csel;
  logic [PRESC_W-1:0] presc;
  logic [1:0]         omode;
  logic [DW-1:0]      load_val, cmp_val, cnt_q;

  dncnt_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .cnt_val   (cnt_q),
    .cmp_evt   (cmp_evt),
    .hold_dbg  (hold_dbg),
    .hold_wait (hold_wait),
    .hold_stop (hold_stop),
    .run       (run),
    .csel      (csel),
    .presc     (presc),
    .rld       (rld),
    .omode     (omode),
    .load_val  (load_val),
    .cmp_val   (cmp_val),
    .flag      (flag_q),
    .restart   (restart),
    .ovw_wr    (ovw_wr),
    .swr       (swr),
    .irq       (irq),
    .bus_rdata (bus_rdata)
  );

  dncnt_prescale #(.NSRC(NSRC)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (swr || restart || ovw_wr),
    .run      (run),
    .csel     (csel),
    .presc    (presc),
    .tick_src (tick_src),
    .fire     (fire)
  );

  dncnt_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .swr      (swr),
    .restart  (restart),
    .ovw_wr   (ovw_wr),
    .wdata    (bus_wdata),
    .load_val (load_val),
    .cmp_val  (cmp_val),
    .rld      (rld),
    .omode    (omode),
    .fire     (fire),
    .cnt      (cnt_q),
    .cmp_evt  (cmp_evt),
    .cmp_out  (cmp_out)
  );

endmodule

// File: rtl/dncnt_timer_chk.sv
module dncnt_timer_chk
  import dncnt_timer_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_we,
  input logic              irq,
  input logic              cmp_out,
  input logic [DW-1:0]     cnt,
  input logic              flag,
  input logic              cmp_evt,
  input logic              fire,
  input logic              swr,
  input logic              restart,
  input logic              ovw_wr,
  input logic [CSRC_W-1:0] csel,
  input logic              rld,
  input logic [1:0]        omode,
  input logic [DW-1:0]     load_val
);

  // R3
  src_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (csel == '0 && !swr && !restart && !ovw_wr) |=> $stable(cnt));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && cnt != '0 && !swr && !restart && !ovw_wr) |=> cnt == $past(cnt) - 1'b1);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && cnt == '0 && rld && !swr && !ovw_wr) |=> cnt == $past(load_val));

  // R6
  evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_evt |=> flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !swr && !(bus_we && bus_addr == AW'(OFS_STAT) && bus_wdata[0])) |=> flag);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |=> !irq);

  // R9
  out_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_evt && omode == 2'b11) |=> cmp_out);

  // R9
  out_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_evt && omode == 2'b10) |=> !cmp_out);

  // R11
  overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    (ovw_wr && !swr) |=> cnt == $past(bus_wdata));

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    swr |=> (cnt == '1 && !flag && !cmp_out));

endmodule

bind dncnt_timer dncnt_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .irq       (irq),
  .cmp_out   (cmp_out),
  .cnt       (cnt_q),
  .flag      (flag_q),
  .cmp_evt   (cmp_evt),
  .fire      (fire),
  .swr       (swr),
  .restart   (restart),
  .ovw_wr    (ovw_wr),
  .csel      (csel),
  .rld       (rld),
  .omode     (omode),
  .load_val  (load_val)
);

// File: tb/dncnt_timer_test.sv
module dncnt_timer_test;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NSRC = 3;

  localparam logic [AW-1:0] A_CTRL = 5'h00;
  localparam logic [AW-1:0] A_STAT = 5'h04;
  localparam logic [AW-1:0] A_LOAD = 5'h08;
  localparam logic [AW-1:0] A_CMP  = 5'h0C;
  localparam logic [AW-1:0] A_CNT  = 5'h10;

  localparam logic [31:0] F_EN    = 32'h1;
  localparam logic [31:0] F_ENMOD = 32'h2;
  localparam logic [31:0] F_IEN   = 32'h4;
  localparam logic [31:0] F_RLD   = 32'h8;
  localparam logic [31:0] F_SWR   = 32'h1_0000;
  localparam logic [31:0] F_OVW   = 32'h2_0000;
  localparam logic [31:0] F_DBG   = 32'h4_0000;
  localparam logic [31:0] F_WAIT  = 32'h8_0000;
  localparam logic [31:0] F_STOP  = 32'h20_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic            bus_we = 1'b0;
  logic [DW-1:0]   bus_rdata;
  logic [NSRC-1:0] tick_src = 3'b101;
  logic            hold_dbg = 1'b0;
  logic            hold_wait = 1'b0;
  logic            hold_stop = 1'b0;
  logic            irq, cmp_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dncnt_timer #(.AW(AW), .DW(DW), .NSRC(NSRC)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_src(tick_src),
    .hold_dbg(hold_dbg), .hold_wait(hold_wait), .hold_stop(hold_stop),
    .irq(irq), .cmp_out(cmp_out)
  );

  function automatic logic [31:0] cw(input int cs, input int om, input int pr,
                                     input logic [31:0] fl);
    return fl | (32'(pr) << 4) | (32'(om) << 22) | (32'(cs) << 24);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // enable for k idle clocks: k+1 count edges in total
  task automatic run_cnt(input logic [31:0] c, input int k);
    bus_write(A_CTRL, c | F_EN);
    repeat (k) @(negedge clk);
    bus_write(A_CTRL, c & ~F_EN);
  endtask

  task automatic expect_cnt(input string req, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(A_CNT, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    bus_read(A_STAT, d); chk("R1 status", d, 32'h0);
    bus_read(A_LOAD, d); chk("R1 load", d, 32'hFFFF_FFFF);
    bus_read(A_CMP, d);  chk("R1 compare", d, 32'h0);
    bus_read(A_CNT, d);  chk("R1 counter", d, 32'hFFFF_FFFF);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 cmp_out", 32'(cmp_out), 32'h0);
  endtask

  task automatic t_src_off();
    run_cnt(cw(0, 0, 0, 0), 4);
    expect_cnt("R3 source 00 holds", 32'hFFFF_FFFF);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW | F_SWR & 32'h0 | 32'h10_0000));
    bus_read(A_CTRL, d); chk("R1 ctrl readback masks bit 20", d, 32'h0002_0000);
    bus_write(A_LOAD, 32'd100);
    expect_cnt("R11 overwrite on", 32'd100);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_LOAD, 32'd200);
    expect_cnt("R11 overwrite off", 32'd100);
    bus_read(A_LOAD, d); chk("R11 load stored", d, 32'd200);
  endtask

  task automatic t_prescale();
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd100);
    bus_write(A_CTRL, 32'h0);
    run_cnt(cw(1, 0, 3, 0), 7);       // 8 ticks / 4
    expect_cnt("R2 divide by 4", 32'd98);
    run_cnt(cw(1, 0, 0, 0), 2);       // 3 ticks / 1
    expect_cnt("R2 R4 divide by 1", 32'd95);
  endtask

  task automatic t_source();
    run_cnt(cw(2, 0, 0, 0), 3);       // tick_src[1] idle
    expect_cnt("R3 source 10", 32'd95);
    run_cnt(cw(3, 0, 0, 0), 3);       // tick_src[2] high
    expect_cnt("R3 source 11", 32'd91);
  endtask

  task automatic t_compare();
    logic [31:0] d;
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd10);
    bus_write(A_CMP, 32'd7);
    bus_write(A_CTRL, cw(1, 1, 0, F_EN | F_IEN));
    repeat (3) @(negedge clk);
    chk("R6 no event before match", 32'(cmp_out), 32'h0);
    chk("R8 irq low before match", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R9 toggle on match", 32'(cmp_out), 32'h1);
    chk("R8 irq lags flag", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 irq rises", 32'(irq), 32'h1);
    bus_write(A_CTRL, cw(1, 1, 0, F_IEN));
    bus_read(A_STAT, d); chk("R6 flag set", d, 32'h1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(A_CTRL, cw(1, 1, 0, 0));
    @(negedge clk);
    chk("R8 mask drops irq", 32'(irq), 32'h0);
    bus_read(A_STAT, d); chk("R8 mask keeps flag", d, 32'h1);
    bus_write(A_CTRL, cw(1, 1, 0, F_IEN));
    @(negedge clk);
    chk("R8 unmask", 32'(irq), 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, d); chk("R7 write 0 ignored", d, 32'h1);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, d); chk("R7 write 1 clears", d, 32'h0);
    chk("R7 R8 irq after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_outmodes();
    logic [31:0] d;
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd5);
    bus_write(A_CMP, 32'd3);
    bus_write(A_CTRL, 32'h0);
    run_cnt(cw(1, 2, 0, 0), 5);
    chk("R9 mode 10 low", 32'(cmp_out), 32'h0);
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd5);
    bus_write(A_CTRL, 32'h0);
    run_cnt(cw(1, 3, 0, 0), 5);
    chk("R9 mode 11 high", 32'(cmp_out), 32'h1);
    bus_write(A_STAT, 32'h1);
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd5);
    bus_write(A_CTRL, 32'h0);
    run_cnt(cw(1, 0, 0, 0), 5);
    chk("R9 mode 00 unchanged", 32'(cmp_out), 32'h1);
    bus_read(A_STAT, d); chk("R6 flag in mode 00", d, 32'h1);
  endtask

  task automatic t_wrap_reload();
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd2);
    bus_write(A_CTRL, 32'h0);
    run_cnt(cw(1, 0, 0, 0), 3);       // 2,1,0,FFFFFFFF,FFFFFFFE
    expect_cnt("R4 wrap", 32'hFFFF_FFFE);
    bus_write(A_CTRL, cw(0, 0, 0, F_OVW));
    bus_write(A_LOAD, 32'd2);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_LOAD, 32'd50);
    run_cnt(cw(1, 0, 0, F_RLD), 3);   // 2,1,0,50,49
    expect_cnt("R5 reload", 32'd49);
  endtask

  task automatic t_restart();
    run_cnt(cw(1, 0, 0, F_ENMOD), 2); // restart 50, then 3 steps
    expect_cnt("R10 restart from load", 32'd47);
    run_cnt(cw(1, 0, 0, 0), 2);
    expect_cnt("R10 resume", 32'd44);
  endtask

  task automatic t_hold();
    hold_dbg = 1'b1;
    run_cnt(cw(1, 0, 0, 0), 2);
    expect_cnt("R13 debug hold", 32'd44);
    run_cnt(cw(1, 0, 0, F_DBG), 2);
    expect_cnt("R13 debug run", 32'd41);
    hold_dbg = 1'b0;
    hold_stop = 1'b1;
    run_cnt(cw(1, 0, 0, 0), 2);
    expect_cnt("R13 stop hold", 32'd41);
    run_cnt(cw(1, 0, 0, F_STOP), 2);
    expect_cnt("R13 stop run", 32'd38);
    hold_stop = 1'b0;
    hold_wait = 1'b1;
    run_cnt(cw(1, 0, 0, 0), 2);
    expect_cnt("R13 wait hold", 32'd38);
    run_cnt(cw(1, 0, 0, F_WAIT), 2);
    expect_cnt("R13 wait run", 32'd35);
    hold_wait = 1'b0;
  endtask

  task automatic t_swr();
    logic [31:0] d;
    bus_write(A_CTRL, cw(0, 3, 0, F_IEN | F_SWR));
    bus_read(A_CTRL, d); chk("R12 ctrl", d, 32'h0);
    bus_read(A_LOAD, d); chk("R12 load", d, 32'hFFFF_FFFF);
    bus_read(A_CMP, d);  chk("R12 compare", d, 32'h0);
    bus_read(A_CNT, d);  chk("R12 counter", d, 32'hFFFF_FFFF);
    bus_read(A_STAT, d); chk("R12 status", d, 32'h0);
    chk("R12 cmp_out", 32'(cmp_out), 32'h0);
    chk("R12 irq", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_src_off();
    t_overwrite();
    t_prescale();
    t_source();
    t_compare();
    t_mask();
    t_w1c();
    t_outmodes();
    t_wrap_reload();
    t_restart();
    t_hold();
    t_swr();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end

endmodule